// File: doc/BRIEF.md
# Buck PWM Cycle Controller

This block sequences the two power switches of a synchronous step-down converter on a fixed switching-cycle grid. A fast system clock drives a cycle counter that marks the start of every switching cycle. Within each cycle a phase sequencer turns the high-side gate on, ends the pulse on the first of several stop events, inserts a break-before-make gap, and then hands the rest of the cycle to the low-side gate. All analog sensing is outside the block and arrives as single-bit comparator flags.

Two operating styles are supported. In forced-PWM mode every cycle carries a high-side pulse whose width is set by the ramp comparator. The pulse has a guaranteed minimum width, is cut short at once by the current limit, and is capped at a maximum duty point. In pulse-skipping mode the high-side pulse has a fixed width. The low-side switch opens as soon as the inductor current drops below the skip threshold, and a whole cycle is skipped when the output is already above setpoint at the cycle start. A one-tick cycle-start strobe is exported so protection logic elsewhere can count cycles. There is no data stream here: all pins are plain level controls and flags, so no valid/ready handshake applies.

Top module: `buck_pwm_seq`

## Requirements
- R1: While `en` is high, `cyc_start` pulses for exactly one tick every CYC_TICKS ticks (100 by default). While `en` is low the cycle position is held at zero and no strobe appears. The first strobe occurs in the tick in which `en` is first seen high.
- R2: While `en` is low, `hs_en` and `ls_en` are both low, including in the same tick in which `en` falls.
- R3: When a cycle carries a high-side pulse, `hs_en` first goes high DEAD_TICKS+1 ticks after the strobe tick. By default this is tick 3, counting the strobe tick as tick 0.
- R4: In PWM mode (`skip_mode`=0), once the pulse has met its minimum width, a high `ramp_trip` sampled in a high-side tick makes that tick the last high-side tick.
- R5: `hs_en` is never high at a cycle position of MAX_TICKS or more (94 by default). With no stop flag, the default pulse occupies ticks 3 to 93.
- R6: A high `ilim_trip` sampled in a high-side tick makes that tick the last high-side tick. This applies in both modes and overrides the minimum width.
- R7: In PWM mode a `ramp_trip` that is already high when the pulse starts still yields a pulse of MIN_ON_TICKS ticks (7 by default, ticks 3 to 9).
- R8: After the high-side pulse ends, both gates are low for DEAD_TICKS ticks. `ls_en` is then high through the next strobe tick inclusive, unless R10 ends it first.
- R9: In skip mode the high-side pulse lasts exactly SKIP_ON_TICKS ticks (30 by default, ticks 3 to 32). `ramp_trip` is ignored.
- R10: In skip mode, a high `below_skip` sampled in a low-side tick makes that tick the last low-side tick. Both gates then stay low until the next cycle start. In PWM mode `below_skip` has no effect.
- R11: In skip mode, a high `above_set` sampled in the strobe tick suppresses the high-side pulse for that whole cycle, and both gates stay low.
- R12: `hs_en` and `ls_en` are never high in the same tick, and `hs_en` never rises in the tick right after `ls_en` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (one tick) |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter enable |
| skip_mode | input | 1 | 1 selects pulse skipping, 0 selects forced PWM |
| ramp_trip | input | 1 | Ramp comparator has crossed the error level |
| ilim_trip | input | 1 | High-side current limit reached |
| below_skip | input | 1 | Inductor current under the skip threshold |
| above_set | input | 1 | Output voltage above setpoint |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| cyc_start | output | 1 | One-tick switching-cycle start strobe |

## Verification
The hardest situations to reach are the ones where two timing rules meet inside one cycle. One is a comparator flag that is already high before the minimum width has elapsed. Another is a skipped cycle, where the decision is made from `above_set` at the strobe tick and the previous cycle has already parked both gates. The bench locks onto a strobe, counts ticks from it, and drives each flag from a chosen tick number. It records both gates across the whole cycle and compares them with the expected on and off windows. Consecutive skip-mode cycles are chained so that the park state and the skipped cycle are entered in sequence.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  typedef enum logic [2:0] {
    PH_OFF    = 3'd0,
    PH_DEAD_H = 3'd1,
    PH_HIGH   = 3'd2,
    PH_DEAD_L = 3'd3,
    PH_LOW    = 3'd4,
    PH_PARK   = 3'd5
  } phase_t;
endpackage

// File: rtl/bpc_cycle_timer.sv
module bpc_cycle_timer #(
  parameter int CYC_TICKS = 100,
  parameter int CW        = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic [CW-1:0] pos,
  output logic          start
);
  localparam logic [CW-1:0] LAST = CW'(CYC_TICKS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pos <= '0;
    else if (!en)         pos <= '0;
    else if (pos == LAST) pos <= '0;
    else                  pos <= pos + 1'b1;
  end

  assign start = en && (pos == '0);
endmodule

// File: rtl/bpc_span_timer.sv
module bpc_span_timer #(
  parameter int SW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [SW-1:0] span
);
  localparam logic [SW-1:0] TOP = {SW{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           span <= '0;
    else if (restart)     span <= '0;
    else if (span != TOP) span <= span + 1'b1;
  end
endmodule

// File: rtl/bpc_phase_seq.sv
module bpc_phase_seq
  import bpc_pkg::*;
#(
  parameter int CW            = 7,
  parameter int SW            = 7,
  parameter int MAX_TICKS     = 94,
  parameter int MIN_ON_TICKS  = 7,
  parameter int SKIP_ON_TICKS = 30,
  parameter int DEAD_TICKS    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          skip_mode,
  input  logic          ramp_trip,
  input  logic          ilim_trip,
  input  logic          below_skip,
  input  logic          above_set,
  input  logic [CW-1:0] pos,
  input  logic          start,
  input  logic [SW-1:0] span,
  output phase_t        phase,
  output logic          restart
);
  localparam logic [CW-1:0] MAX_LAST  = CW'(MAX_TICKS - 1);
  localparam logic [SW-1:0] MIN_LAST  = SW'(MIN_ON_TICKS - 1);
  localparam logic [SW-1:0] SKIP_LAST = SW'(SKIP_ON_TICKS - 1);
  localparam logic [SW-1:0] DEAD_LAST = SW'(DEAD_TICKS - 1);

  phase_t nxt;
  logic   max_hit, min_met, fixed_done, hs_stop, gap_done;

  assign max_hit    = (pos == MAX_LAST);
  assign min_met    = (span >= MIN_LAST);
  assign fixed_done = (span >= SKIP_LAST);
  assign gap_done   = (span == DEAD_LAST);
  assign hs_stop    = max_hit || ilim_trip ||
                      (skip_mode ? fixed_done : (ramp_trip && min_met));

  always_comb begin
    nxt = phase;
    if (!en) begin
      nxt = PH_OFF;
    end else if (start) begin
      if (skip_mode && above_set) nxt = PH_PARK;
      else                        nxt = PH_DEAD_H;
    end else begin
      case (phase)
        PH_DEAD_H: if (gap_done) nxt = PH_HIGH;
        PH_HIGH:   if (hs_stop)  nxt = PH_DEAD_L;
        PH_DEAD_L: if (gap_done) nxt = PH_LOW;
        PH_LOW:    if (skip_mode && below_skip) nxt = PH_PARK;
        default:   nxt = phase;
      endcase
    end
  end

  assign restart = (nxt != phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_OFF;
    else        phase <= nxt;
  end
endmodule

// File: rtl/buck_pwm_seq.sv
module buck_pwm_seq
  import bpc_pkg::*;
#(
  parameter int CLK_HZ       = 100_000_000,
  parameter int SW_HZ        = 1_000_000,
  parameter int MAX_DUTY_PCT = 94,
  parameter int MIN_ON_NS    = 70,
  parameter int SKIP_ON_NS   = 300,
  parameter int DEAD_TICKS   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic skip_mode,
  input  logic ramp_trip,
  input  logic ilim_trip,
  input  logic below_skip,
  input  logic above_set,
  output logic hs_en,
  output logic ls_en,
  output logic cyc_start
);
  localparam int CYC_TICKS     = CLK_HZ / SW_HZ;
  localparam int MAX_TICKS     = (CYC_TICKS * MAX_DUTY_PCT) / 100;
  localparam int TICK_NS       = 1_000_000_000 / CLK_HZ;
  localparam int MIN_ON_TICKS  = (MIN_ON_NS + TICK_NS - 1) / TICK_NS;
  localparam int SKIP_ON_TICKS = (SKIP_ON_NS + TICK_NS - 1) / TICK_NS;
  localparam int CW            = $clog2(CYC_TICKS);
  localparam int SW            = $clog2(CYC_TICKS + 1);

  logic [CW-1:0] pos;
  logic [SW-1:0] span;
  logic          restart;
  phase_t        phase;

  bpc_cycle_timer #(.CYC_TICKS(CYC_TICKS), .CW(CW)) u_cycle (
    .clk(clk), .rst_n(rst_n), .en(en), .pos(pos), .start(cyc_start)
  );

  bpc_span_timer #(.SW(SW)) u_span (
    .clk(clk), .rst_n(rst_n), .restart(restart), .span(span)
  );

  bpc_phase_seq #(
    .CW(CW), .SW(SW), .MAX_TICKS(MAX_TICKS), .MIN_ON_TICKS(MIN_ON_TICKS),
    .SKIP_ON_TICKS(SKIP_ON_TICKS), .DEAD_TICKS(DEAD_TICKS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .skip_mode(skip_mode),
    .ramp_trip(ramp_trip), .ilim_trip(ilim_trip), .below_skip(below_skip),
    .above_set(above_set), .pos(pos), .start(cyc_start), .span(span),
    .phase(phase), .restart(restart)
  );

  assign hs_en = en && (phase == PH_HIGH);
  assign ls_en = en && (phase == PH_LOW);
endmodule

// File: rtl/bpc_checker.sv
module bpc_checker #(
  parameter int CYC_TICKS = 100,
  parameter int MAX_TICKS = 94,
  parameter int CW        = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          ilim_trip,
  input logic          hs_en,
  input logic          ls_en,
  input logic          cyc_start,
  input logic [CW-1:0] tick_cnt
);
  logic [CW:0] gap;
  logic        seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap <= '0; seen <= 1'b0;
    end else if (!en) begin
      gap <= '0; seen <= 1'b0;
    end else if (cyc_start) begin
      gap <= '0; seen <= 1'b1;
    end else begin
      gap <= gap + 1'b1;
    end
  end

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en && ls_en)); // R12
  AST_HS_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> !$past(ls_en)); // R12
  AST_GATES_OFF_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!hs_en && !ls_en)); // R2
  AST_STROBE_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> !cyc_start); // R1
  AST_STROBE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cyc_start && seen) |-> (gap == (CW+1)'(CYC_TICKS - 1))); // R1
  AST_MAX_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick_cnt >= CW'(MAX_TICKS)) |-> !hs_en); // R5
  AST_ILIM_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_en && ilim_trip) |=> !hs_en); // R6
endmodule

bind buck_pwm_seq bpc_checker #(
  .CYC_TICKS(CYC_TICKS), .MAX_TICKS(MAX_TICKS), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .ilim_trip(ilim_trip),
  .hs_en(hs_en), .ls_en(ls_en), .cyc_start(cyc_start), .tick_cnt(pos)
);

// File: tb/tb_buck_pwm_seq.sv
module tb_buck_pwm_seq;
  logic clk = 1'b0;
  logic rst_n, en, skip_mode, ramp_trip, ilim_trip, below_skip, above_set;
  logic hs_en, ls_en, cyc_start;

  int checks = 0;
  int errors = 0;
  int overlap = 0;
  logic hs_log [0:100];
  logic ls_log [0:100];
  logic st_log [0:100];

  always #5 clk = ~clk;

  buck_pwm_seq dut (
    .clk(clk), .rst_n(rst_n), .en(en), .skip_mode(skip_mode),
    .ramp_trip(ramp_trip), .ilim_trip(ilim_trip), .below_skip(below_skip),
    .above_set(above_set), .hs_en(hs_en), .ls_en(ls_en), .cyc_start(cyc_start)
  );

  always @(negedge clk) if (hs_en && ls_en) overlap++;

  task automatic check_bit(input string req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  // Caller is at the strobe tick (tick 0). Records ticks 1..100; tick 100 is the next strobe.
  task automatic run_cycle(input int trip_at, input int ilim_at, input int zc_at,
                           input logic above_now, input logic above_end);
    above_set = above_now;
    for (int t = 1; t <= 100; t++) begin
      @(negedge clk);
      hs_log[t] = hs_en; ls_log[t] = ls_en; st_log[t] = cyc_start;
      ramp_trip  = (trip_at >= 0) && (t >= trip_at) && (t < 100);
      ilim_trip  = (ilim_at >= 0) && (t == ilim_at);
      below_skip = (zc_at >= 0) && (t >= zc_at) && (t < 100);
      if (t == 100) above_set = above_end;
    end
  endtask

  task automatic check_window(input string req, input bit use_hs, input int lo, input int hi);
    int bad = -1;
    logic got_b = 1'b0;
    logic exp_b = 1'b0;
    for (int t = 1; t <= 100; t++) begin
      logic g;
      logic e;
      g = use_hs ? hs_log[t] : ls_log[t];
      e = (t >= lo) && (t <= hi);
      if (g !== e && bad < 0) begin bad = t; got_b = g; exp_b = e; end
    end
    checks++;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s %s window [%0d..%0d]: tick %0d got %0b expected %0b",
               req, use_hs ? "hs_en" : "ls_en", lo, hi, bad, got_b, exp_b);
    end
  endtask

  task automatic check_strobes(input string req);
    int bad = -1;
    for (int t = 1; t <= 100; t++)
      if (st_log[t] !== (t == 100) && bad < 0) bad = t;
    checks++;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s strobe at tick %0d: got %0b expected %0b",
               req, bad, st_log[bad], (bad == 100));
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; en = 1'b0; skip_mode = 1'b0; ramp_trip = 1'b0;
    ilim_trip = 1'b0; below_skip = 1'b0; above_set = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_bit("R2", "hs_en after reset", hs_en, 1'b0);
    check_bit("R2", "ls_en after reset", ls_en, 1'b0);
    check_bit("R1", "no strobe while disabled", cyc_start, 1'b0);
  endtask

  task automatic t_enable_free_run;
    en = 1'b1;
    #1 check_bit("R1", "strobe in enable tick", cyc_start, 1'b1);
    run_cycle(-1, -1, -1, 1'b0, 1'b0);
    check_strobes("R1");
    check_window("R3 R5", 1'b1, 3, 93);
    check_window("R8", 1'b0, 96, 100);
  endtask

  task automatic t_ramp_trip;
    run_cycle(40, -1, -1, 1'b0, 1'b0);
    check_window("R4", 1'b1, 3, 40);
    check_window("R8", 1'b0, 43, 100);
  endtask

  task automatic t_min_on;
    run_cycle(1, -1, -1, 1'b0, 1'b0);
    check_window("R7", 1'b1, 3, 9);
    check_window("R7 R8", 1'b0, 12, 100);
  endtask

  task automatic t_ilim;
    run_cycle(-1, 5, -1, 1'b0, 1'b0);
    check_window("R6", 1'b1, 3, 5);
    check_window("R6 R8", 1'b0, 8, 100);
  endtask

  task automatic t_zc_in_pwm;
    run_cycle(-1, -1, 50, 1'b0, 1'b0);
    check_window("R10 pwm ignore", 1'b0, 96, 100);
  endtask

  task automatic t_skip_sequence;
    skip_mode = 1'b1;
    run_cycle(10, -1, 60, 1'b0, 1'b1);
    check_window("R9", 1'b1, 3, 32);
    check_window("R10", 1'b0, 35, 60);
    run_cycle(-1, -1, -1, 1'b1, 1'b0);
    check_window("R11", 1'b1, 1, 0);
    check_window("R11", 1'b0, 1, 0);
    check_strobes("R1 skip");
    run_cycle(-1, -1, -1, 1'b0, 1'b0);
    check_window("R9", 1'b1, 3, 32);
    check_window("R8 skip", 1'b0, 35, 100);
    run_cycle(-1, 10, -1, 1'b0, 1'b0);
    check_window("R6 skip", 1'b1, 3, 10);
    skip_mode = 1'b0;
    run_cycle(-1, -1, -1, 1'b0, 1'b0);
    check_window("R5 back to pwm", 1'b1, 3, 93);
  endtask

  task automatic t_disable_mid_pulse;
    int stray = 0;
    repeat (20) @(negedge clk);
    check_bit("R2", "hs_en high before disable", hs_en, 1'b1);
    en = 1'b0;
    #1 check_bit("R2", "hs_en in disable tick", hs_en, 1'b0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (hs_en || ls_en || cyc_start) stray++;
    end
    checks++;
    if (stray != 0) begin
      errors++;
      $display("FAIL R1 R2 activity while disabled: got %0d ticks expected 0", stray);
    end
    en = 1'b1;
    #1 check_bit("R1", "strobe on re-enable", cyc_start, 1'b1);
    run_cycle(-1, -1, -1, 1'b0, 1'b0);
    check_strobes("R1 re-enable");
    check_window("R3", 1'b1, 3, 93);
  endtask

  bit done = 1'b0;

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_enable_free_run();
    t_ramp_trip();
    t_min_on();
    t_ilim();
    t_zc_in_pwm();
    t_skip_sequence();
    t_disable_mid_pulse();
    checks++;
    if (overlap != 0) begin
      errors++;
      $display("FAIL R12 overlapping gates: got %0d ticks expected 0", overlap);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule